// File: doc/BRIEF.md
# CPU Clock Source Switch Controller

This block decides which clock drives the CPU and how fast it runs. There are two sources: a fast main clock and a slow sub clock. The sub clock arrives as a one-cycle tick input in the main clock domain. The output is a clock-enable pulse, `cpuEn`, that marks each machine cycle. The block also drives an enable for the main oscillator. Software controls it through a small register port with two registers. The mode register chooses the source and can ask for the main oscillator to stop. The power register chooses the main-clock divider.

A register write does not change the CPU rate at once. The block compares the written settings with the setting in force. If the change is permitted, it starts a switch and raises a busy flag. The old rate keeps running until a fixed number of old-rate machine cycles have passed. At the end of the switch the new setting takes over on a machine-cycle boundary. The switch delay is 16 cycles when going from the divide-by-4 main setting to the divide-by-64 setting, and 8 cycles when going from divide-by-8 to divide-by-64. Every other permitted change takes 1 cycle.

The sub clock can be entered only from the divide-by-4 main setting, and left only back to that setting. A change that breaks these rules is dropped and sets a sticky error flag. Writes that arrive during a switch are stored. The latest of them is judged once the current switch has finished.

Top module: `cpu_clk_switch`

## Requirements
- R1: After reset the CPU runs from the main clock divided by 64 (one `cpuEn` pulse every 64 clock cycles), `mainOscEn` is 1, and the mode, power and status registers all read 0.
- R2: With the main clock selected, the power register bits 1:0 set the `cpuEn` period in main clock cycles: 00 gives 64, 01 (reserved) gives 64, 10 gives 8 and 11 gives 4. A write that leaves the derived setting unchanged starts no switch (busy stays 0).
- R3: When mode bit 0 is 1, the sub clock is the source and `cpuEn` pulses once every 4 `subTick` pulses, whatever the power bits hold.
- R4: A permitted change is applied after D `cpuEn` pulses at the old rate, counted from the cycle busy rises. D is 8 for divide-by-8 to divide-by-64, 16 for divide-by-4 to divide-by-64, and 1 for every other permitted change. The first interval after the switch already has the new length.
- R5: Only two moves between sources are permitted: main divide-by-4 to sub clock, and sub clock to main divide-by-4 while mode bit 3 is 0. Any other source change is not applied. Mode bit 0 and the power bits then reload the setting in force, and status bit 2 (error) is set and stays set until reset.
- R6: `mainOscEn` is 0 only while mode bit 3 is 1 and the sub clock is the active source. Setting bit 3 while the main clock is active leaves the oscillator enabled and `cpuEn` running.
- R7: Status bit 1 (busy) is 1 while a switch is pending. A write made while busy does not alter the switch in progress. The latest such write is applied, with its own delay, after that switch completes.
- R8: Read address 0 returns the mode register (bit 0 source, bit 3 oscillator stop, bits 2:1 stored as written). Address 1 returns the power register in bits 1:0. Address 2 returns status: bit 0 sub clock active, bit 1 busy, bit 2 error. Address 3 reads 0. Write address 0 selects the mode register and 1 the power register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock; all logic is synchronous to it |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 1 | Write target: 0 mode, 1 power |
| wrData | input | 4 | Write data |
| rdAddr | input | 2 | Read address |
| subTick | input | 1 | One-cycle pulse per sub clock period |
| rdData | output | 4 | Read data for `rdAddr` |
| cpuEn | output | 1 | One-cycle CPU machine-cycle enable |
| mainOscEn | output | 1 | Main oscillator enable |

## Verification
Directed writes cover each transition that has its own delay length: 1, 8 and 16 cycles. They also cover each divider code, including the reserved one, so that a wrong delay or a wrong period is caught. Separate cases exercise the forbidden source moves, the oscillator-stop request made while the main clock runs, and a write that lands in the middle of a switch. These separate the rejection path, the oscillator gating rule and the deferred-write rule. A seeded random series of single writes to either register then walks the block through mixed legal, illegal and no-change updates. Each one is judged by a bench model of the active setting and the register contents.

// File: rtl/clk_switch_pkg.sv
package clk_switch_pkg;

  // Derived CPU clock setting
  typedef enum logic [1:0] {
    CFG_SLOW = 2'd0,   // main clock, slowest divider
    CFG_MID  = 2'd1,   // main clock, middle divider
    CFG_FAST = 2'd2,   // main clock, fastest divider
    CFG_SUB  = 2'd3    // sub clock
  } cfg_e;

  // Control-to-datapath strobes
  typedef struct packed {
    cfg_e curCfg;
    cfg_e nextCfg;
    logic apply;
  } swStrobe_t;

  function automatic cfg_e cfgOf(input logic src, input logic [1:0] div);
    if (src) return CFG_SUB;
    case (div)
      2'b10:   return CFG_MID;
      2'b11:   return CFG_FAST;
      default: return CFG_SLOW;
    endcase
  endfunction

endpackage

// File: rtl/clk_switch_ctrl.sv
module clk_switch_ctrl
  import clk_switch_pkg::*;
#(
  parameter int DLY_MID_SLOW  = 8,
  parameter int DLY_FAST_SLOW = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wrEn,
  input  logic       wrAddr,
  input  logic [3:0] wrData,
  input  logic [1:0] rdAddr,
  input  logic       cpuEn,
  output swStrobe_t  strobe,
  output logic [3:0] rdData,
  output logic       mainOscEn
);

  localparam int DLY_W = $clog2(DLY_FAST_SLOW + 1);

  typedef enum logic {ST_IDLE, ST_WAIT} state_e;

  state_e           state;
  logic [3:0]       modeReg;
  logic [1:0]       divReg;
  logic             pendReq;
  logic             actSrc;
  logic [1:0]       actDiv;
  logic             tgtSrc;
  logic [1:0]       tgtDiv;
  logic [DLY_W-1:0] waitCnt;
  logic             errSticky;

  cfg_e             actCfg;
  cfg_e             reqCfg;
  cfg_e             tgtCfg;
  logic             reqLegal;
  logic [DLY_W-1:0] reqDelay;
  logic             applyNow;

  function automatic logic isLegal(input cfg_e from, input cfg_e to, input logic oscOff);
    if (to == CFG_SUB)   return (from == CFG_FAST) || (from == CFG_SUB);
    if (from == CFG_SUB) return (to == CFG_FAST) && !oscOff;
    return 1'b1;
  endfunction

  assign actCfg   = cfgOf(actSrc, actDiv);
  assign reqCfg   = cfgOf(modeReg[0], divReg);
  assign tgtCfg   = cfgOf(tgtSrc, tgtDiv);
  assign reqLegal = isLegal(actCfg, reqCfg, modeReg[3]);

  always_comb begin
    if (actCfg == CFG_MID && reqCfg == CFG_SLOW)
      reqDelay = DLY_W'(DLY_MID_SLOW);
    else if (actCfg == CFG_FAST && reqCfg == CFG_SLOW)
      reqDelay = DLY_W'(DLY_FAST_SLOW);
    else
      reqDelay = DLY_W'(1);
  end

  assign applyNow = (state == ST_WAIT) && cpuEn && (waitCnt == DLY_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      modeReg   <= '0;
      divReg    <= '0;
      pendReq   <= 1'b0;
      actSrc    <= 1'b0;
      actDiv    <= '0;
      tgtSrc    <= 1'b0;
      tgtDiv    <= '0;
      waitCnt   <= '0;
      errSticky <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (pendReq) begin
            pendReq <= 1'b0;
            if (reqCfg != actCfg) begin
              if (reqLegal) begin
                tgtSrc  <= modeReg[0];
                tgtDiv  <= divReg;
                waitCnt <= reqDelay;
                state   <= ST_WAIT;
              end else begin
                errSticky  <= 1'b1;
                modeReg[0] <= actSrc;
                divReg     <= actDiv;
              end
            end
          end
        end
        ST_WAIT: begin
          if (cpuEn) begin
            if (applyNow) begin
              actSrc <= tgtSrc;
              actDiv <= tgtDiv;
              state  <= ST_IDLE;
            end else begin
              waitCnt <= waitCnt - DLY_W'(1);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
      // Bus writes override a same-cycle reload
      if (wrEn) begin
        pendReq <= 1'b1;
        if (!wrAddr) modeReg <= wrData;
        else         divReg  <= wrData[1:0];
      end
    end
  end

  assign strobe.curCfg  = actCfg;
  assign strobe.nextCfg = tgtCfg;
  assign strobe.apply   = applyNow;

  assign mainOscEn = !(modeReg[3] && actCfg == CFG_SUB);

  always_comb begin
    case (rdAddr)
      2'd0:    rdData = modeReg;
      2'd1:    rdData = {2'b00, divReg};
      2'd2:    rdData = {1'b0, errSticky, state == ST_WAIT, actCfg == CFG_SUB};
      default: rdData = 4'd0;
    endcase
  end

  // R4: the active setting changes only right after a machine-cycle pulse
  assert_switch_on_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    (actCfg != $past(actCfg)) |-> $past(cpuEn));

  // R5: the sub clock is entered only from the fastest main setting
  assert_sub_entry_R5: assert property (@(posedge clk) disable iff (rst)
    (actCfg == CFG_SUB && $past(actCfg) != CFG_SUB) |-> $past(actCfg) == CFG_FAST);

  // R5: leaving the sub clock lands on the fastest main setting
  assert_sub_exit_R5: assert property (@(posedge clk) disable iff (rst)
    (actCfg != CFG_SUB && $past(actCfg) == CFG_SUB) |-> actCfg == CFG_FAST);

  // R5: the error flag never clears outside reset
  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    errSticky |=> errSticky);

  // R6: the oscillator is off only while the sub clock is active
  assert_osc_only_sub_R6: assert property (@(posedge clk) disable iff (rst)
    !mainOscEn |-> actCfg == CFG_SUB);

endmodule

// File: rtl/clk_switch_datapath.sv
module clk_switch_datapath
  import clk_switch_pkg::*;
#(
  parameter int DIV_SLOW = 64,
  parameter int DIV_MID  = 8,
  parameter int DIV_FAST = 4,
  parameter int SUB_DIV  = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      subTick,
  input  swStrobe_t strobe,
  output logic      cpuEn
);

  localparam int CNT_W = $clog2(DIV_SLOW);

  logic [CNT_W-1:0] preCnt;
  logic [CNT_W-1:0] preLim;
  logic             curTick;
  logic             nextTick;

  always_comb begin
    case (strobe.curCfg)
      CFG_MID:  preLim = CNT_W'(DIV_MID - 1);
      CFG_FAST: preLim = CNT_W'(DIV_FAST - 1);
      CFG_SUB:  preLim = CNT_W'(SUB_DIV - 1);
      default:  preLim = CNT_W'(DIV_SLOW - 1);
    endcase
  end

  assign curTick  = (strobe.curCfg == CFG_SUB) ? subTick : 1'b1;
  assign nextTick = (strobe.nextCfg == CFG_SUB) ? subTick : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      preCnt <= '0;
      cpuEn  <= 1'b0;
    end else if (strobe.apply) begin
      // New rate starts on this pulse; count this cycle's tick of the new source
      preCnt <= {{(CNT_W-1){1'b0}}, nextTick};
      cpuEn  <= 1'b0;
    end else if (curTick) begin
      if (preCnt == preLim) begin
        preCnt <= '0;
        cpuEn  <= 1'b1;
      end else begin
        preCnt <= preCnt + CNT_W'(1);
        cpuEn  <= 1'b0;
      end
    end else begin
      cpuEn <= 1'b0;
    end
  end

  // R2: a machine-cycle pulse lasts one clock
  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    cpuEn |=> !cpuEn);

  // R2: the prescaler never runs past the active divider limit
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
    preCnt <= preLim);

endmodule

// File: rtl/cpu_clk_switch.sv
module cpu_clk_switch
  import clk_switch_pkg::*;
#(
  parameter int DIV_SLOW      = 64,
  parameter int DIV_MID       = 8,
  parameter int DIV_FAST      = 4,
  parameter int SUB_DIV       = 4,
  parameter int DLY_MID_SLOW  = 8,
  parameter int DLY_FAST_SLOW = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wrEn,
  input  logic       wrAddr,
  input  logic [3:0] wrData,
  input  logic [1:0] rdAddr,
  input  logic       subTick,
  output logic [3:0] rdData,
  output logic       cpuEn,
  output logic       mainOscEn
);

  swStrobe_t strobe;

  clk_switch_ctrl #(
    .DLY_MID_SLOW (DLY_MID_SLOW),
    .DLY_FAST_SLOW(DLY_FAST_SLOW)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .rdAddr   (rdAddr),
    .cpuEn    (cpuEn),
    .strobe   (strobe),
    .rdData   (rdData),
    .mainOscEn(mainOscEn)
  );

  clk_switch_datapath #(
    .DIV_SLOW(DIV_SLOW),
    .DIV_MID (DIV_MID),
    .DIV_FAST(DIV_FAST),
    .SUB_DIV (SUB_DIV)
  ) u_datapath (
    .clk    (clk),
    .rst    (rst),
    .subTick(subTick),
    .strobe (strobe),
    .cpuEn  (cpuEn)
  );

endmodule

// File: tb/cpu_clk_switch_bench.sv
`timescale 1ns/100ps
module cpu_clk_switch_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wrEn = 1'b0;
  logic       wrAddr = 1'b0;
  logic [3:0] wrData = 4'd0;
  logic [1:0] rdAddr = 2'd2;
  logic       subTick = 1'b0;
  logic [3:0] rdData;
  logic       cpuEn;
  logic       mainOscEn;

  int checks = 0;
  int errors = 0;
  int pulseCnt = 0;
  logic pulseSub = 1'b0;

  // Bench model: 0 slow, 1 mid, 2 fast, 3 sub
  int         expCfg = 0;
  logic       expSrc = 1'b0;
  logic [1:0] expDiv = 2'd0;
  logic [3:0] shMode = 4'd0;
  logic [1:0] shDiv  = 2'd0;
  logic       expErr = 1'b0;

  cpu_clk_switch u_cpu_clk_switch (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .subTick(subTick), .rdData(rdData), .cpuEn(cpuEn),
    .mainOscEn(mainOscEn)
  );

  always #2.5 clk = ~clk;

  // Sub clock tick: one pulse every 5 main cycles, changed away from sampling
  initial begin
    int ph = 0;
    forever begin
      @(posedge clk);
      #1 subTick = (ph == 4);
      ph = (ph == 4) ? 0 : ph + 1;
    end
  end

  // Count machine-cycle pulses seen while busy
  always begin
    @(negedge clk);
    #0.2;
    if (cpuEn) begin
      pulseSub = subTick;
      if (rdData[1]) pulseCnt++;
    end
  end

  function automatic int cfgOf(logic src, logic [1:0] div);
    if (src) return 3;
    if (div == 2'b10) return 1;
    if (div == 2'b11) return 2;
    return 0;
  endfunction

  function automatic int periodOf(int c);
    case (c)
      1: return 8;
      2: return 4;
      3: return 4;
      default: return 64;
    endcase
  endfunction

  function automatic bit legalOf(int from, int to, logic oscOff);
    if (to == 3) return (from == 2) || (from == 3);
    if (from == 3) return (to == 2) && !oscOff;
    return 1'b1;
  endfunction

  function automatic int delayOf(int from, int to);
    if (from == 1 && to == 0) return 8;
    if (from == 2 && to == 0) return 16;
    return 1;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic readReg(input logic [1:0] a, output logic [3:0] v);
    @(negedge clk);
    #0.5 rdAddr = a;
    #0.5 v = rdData;
    #0.5 rdAddr = 2'd2;
  endtask

  task automatic busWrite(input logic a, input logic [3:0] d);
    @(negedge clk);
    #1;
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    #1 wrEn = 1'b0;
  endtask

  // Count ticks from one pulse (inclusive) to the next; assumes now at a pulse+1 cycle
  task automatic measureFrom(input bit sub, input logic firstTick, output int ticks);
    ticks = sub ? int'(firstTick) : 1;
    for (int i = 0; i < 400; i++) begin
      if (cpuEn) break;
      ticks += sub ? int'(subTick) : 1;
      @(negedge clk);
      #1;
    end
  endtask

  task automatic checkPeriod(input int expN, input bit sub, input string tag);
    int ticks;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      #1;
      if (cpuEn) break;
    end
    ticks = sub ? int'(subTick) : 1;
    @(negedge clk);
    #1;
    measureFrom(sub, ticks[0], ticks);
    check(ticks == expN, tag, ticks, expN);
  endtask

  task automatic observeSwitch(input int expD, input int newCfg, input bit measure);
    bit seen = 0;
    int ticks;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      #1;
      if (rdData[1]) begin seen = 1; break; end
    end
    check(seen, "R7 busy rises for a permitted change", int'(seen), 1);
    for (int i = 0; i < 3000; i++) begin
      if (!rdData[1]) break;
      @(negedge clk);
      #1;
    end
    check(pulseCnt == expD, "R4 old-rate pulses while busy", pulseCnt, expD);
    if (measure) begin
      measureFrom(newCfg == 3, pulseSub, ticks);
      check(ticks == periodOf(newCfg), "R2/R3 first interval after switch", ticks, periodOf(newCfg));
    end
  endtask

  task automatic doWrite(input logic a, input logic [3:0] d);
    int tgt;
    logic [3:0] v;
    bit stayIdle;
    if (!a) shMode = d; else shDiv = d[1:0];
    tgt = cfgOf(shMode[0], shDiv);
    pulseCnt = 0;
    busWrite(a, d);
    if (tgt == expCfg) begin
      stayIdle = 1;
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        #1;
        if (rdData[1]) stayIdle = 0;
      end
      check(stayIdle, "R2 unchanged setting starts no switch", int'(!stayIdle), 0);
    end else if (legalOf(expCfg, tgt, shMode[3])) begin
      observeSwitch(delayOf(expCfg, tgt), tgt, 1);
      expCfg = tgt; expSrc = shMode[0]; expDiv = shDiv;
    end else begin
      expErr = 1'b1;
      shMode[0] = expSrc; shDiv = expDiv;
      repeat (3) @(negedge clk);
      #1;
      check(rdData[2:1] == 2'b10, "R5 rejected change: error set, not busy", rdData[2:1], 2);
      readReg(2'd0, v);
      check(v == shMode, "R5 mode bit reloaded", v, shMode);
      readReg(2'd1, v);
      check(v == {2'b00, shDiv}, "R5 power bits reloaded", v, shDiv);
    end
    #0.1;
    check(mainOscEn == !(shMode[3] && expCfg == 3), "R6 oscillator enable",
          mainOscEn, !(shMode[3] && expCfg == 3));
    check(rdData[0] == (expCfg == 3), "R8 status source bit", rdData[0], expCfg == 3);
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] v;
    void'($urandom(32'd4711));
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    readReg(2'd0, v); check(v == 4'd0, "R1 mode after reset", v, 0);
    readReg(2'd1, v); check(v == 4'd0, "R1 power after reset", v, 0);
    readReg(2'd2, v); check(v == 4'd0, "R1 status after reset", v, 0);
    check(mainOscEn == 1'b1, "R1 oscillator enabled", mainOscEn, 1);
    checkPeriod(64, 0, "R1 reset period");

    // R2: reserved code is the slow divider, no switch
    doWrite(1'b1, 4'b0001);
    checkPeriod(64, 0, "R2 reserved code period");
    readReg(2'd1, v); check(v == 4'd1, "R8 power readback", v, 1);

    // R2, R4: walk the main dividers
    doWrite(1'b1, 4'b0010);   // slow -> mid, 1
    doWrite(1'b1, 4'b0011);   // mid -> fast, 1
    doWrite(1'b1, 4'b0000);   // fast -> slow, 16
    doWrite(1'b1, 4'b0010);   // slow -> mid, 1
    doWrite(1'b1, 4'b0000);   // mid -> slow, 8

    // R5: sub clock from the slow setting is refused
    doWrite(1'b0, 4'b0001);
    readReg(2'd2, v); check(v[2] == 1'b1, "R5 error flag sticky", v[2], 1);

    // R6: stop request while the main clock runs
    doWrite(1'b1, 4'b0011);   // -> fast
    doWrite(1'b0, 4'b1000);   // stop request, still main
    checkPeriod(4, 0, "R6 CPU keeps running on main clock");

    // R3: enter the sub clock with the stop request already set
    doWrite(1'b0, 4'b1001);
    checkPeriod(4, 1, "R3 sub clock period");
    doWrite(1'b1, 4'b0000);   // power bits ignored on sub clock
    checkPeriod(4, 1, "R3 power bits ignored on sub clock");
    doWrite(1'b1, 4'b0011);
    doWrite(1'b0, 4'b1000);   // return with oscillator stopped: refused
    doWrite(1'b0, 4'b0001);   // oscillator back on
    doWrite(1'b0, 4'b0000);   // back to fast main

    // R7: write held during a switch
    shDiv = 2'b00;
    pulseCnt = 0;
    busWrite(1'b1, 4'b0000);  // fast -> slow, 16
    busWrite(1'b1, 4'b0010);  // arrives while busy
    readReg(2'd2, v); check(v[1] == 1'b1, "R7 busy readable during switch", v[1], 1);
    observeSwitch(16, 0, 0);
    pulseCnt = 0;
    observeSwitch(1, 1, 1);
    shDiv = 2'b10; expCfg = 1; expSrc = 1'b0; expDiv = 2'b10;
    readReg(2'd1, v); check(v == 4'd2, "R7 latest held write applied", v, 2);

    // Random single writes
    for (int n = 0; n < 40; n++) begin
      logic a;
      logic [3:0] d;
      a = 1'($urandom % 2);
      d = 4'($urandom % 16);
      doWrite(a, d);
    end
    readReg(2'd2, v); check(v[2] == expErr, "R5 error flag after random series", v[2], expErr);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule